// File: doc/BRIEF.md
# Control Endpoint Mode Handler

This block holds the per-endpoint control state between a packet engine and the firmware of a full-speed device. A 4-bit mode field decides how the endpoint answers each SETUP, IN and OUT transaction (acknowledge, refuse with NAK, stall, or stay silent). A counter register records the data toggle, a data-valid flag and the byte count of the last accepted data packet. The packet engine presents one completed transaction per strobe, already decoded, and the block answers with a registered handshake choice and an interrupt pulse.

After each transaction the hardware writes its results back and locks the registers it touched, so firmware cannot overwrite fresh results before it has seen them. A read strobe releases each lock. When a status-stage OUT is accepted in the "ACK IN / status OUT" mode, the hardware moves the mode on to "NAK IN / status OUT" by itself. When a SETUP token appears, the SETUP flag is set and locked at once, before the data phase ends.

Top module: `ctl_ep_mode`

## Requirements
- R1: After reset `mode_reg` and `cnt_reg` read zero, and `hs_valid` and `ep_irq` are low.
- R2: One cycle after `tok_valid`, `hs_valid`/`hs_code` show the answer (`hs_code` 1 = ACK, 2 = NAK, 3 = STALL; `hs_valid` low and `hs_code` 0 when silent). Mode 0000 is silent to everything. For IN: 0011 STALL; 1101, 1111 ACK; 0001, 1000, 1001, 1100, 1110 NAK; other modes silent. For OUT with a good packet (`tok_ok`): 0011 STALL; 1001, 1110, 1111 ACK; 0001, 1000, 1100, 1101 NAK; other modes silent. An OUT with a bad packet gets no answer. `tok_kind` is 0 = SETUP, 1 = IN, 2 = OUT.
- R3: In every nonzero mode, a good SETUP is answered with ACK, and a SETUP never gets NAK or STALL.
- R4: An accepted SETUP or OUT loads `cnt_reg` with bit 7 = `tok_dtog`, bit 6 = 1 (data valid), bits 5:0 = `tok_len`. No other transaction changes `cnt_reg`.
- R5: `mode_reg` bit 4 is the ACK flag. An accepted SETUP or OUT sets it, an ACKed IN loads it from `host_ack`, and a NAK or STALL clears it. A silent transaction leaves it unchanged.
- R6: An accepted OUT in mode 1111 changes the mode field (`mode_reg` bits 3:0) to 1110. No other transaction changes the mode field.
- R7: Any answered transaction locks `mode_reg`, and any update of `cnt_reg` locks `cnt_reg`. While a register is locked, firmware writes to it are ignored. `fw_mode_rd` and `fw_cnt_rd` each release their own lock. An unlocked register takes the written value: for `mode_reg`, bit 7 = SETUP flag, bit 4 = ACK flag, bits 3:0 = mode; for `cnt_reg`, all bits.
- R8: `setup_seen` in a nonzero mode sets `mode_reg` bit 7 and locks `mode_reg` on the next edge.
- R9: `ep_irq` pulses for one cycle together with an ACK or STALL answer, and stays low for NAK and for silence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| setup_seen | input | 1 | SETUP token detected, data phase pending |
| tok_valid | input | 1 | Transaction complete strobe |
| tok_kind | input | 2 | 0 SETUP, 1 IN, 2 OUT |
| tok_ok | input | 1 | Data packet received without error |
| tok_dtog | input | 1 | Data toggle of received packet |
| tok_len | input | CNT_W | Received byte count |
| host_ack | input | 1 | Host acknowledged the IN data |
| fw_mode_wr | input | 1 | Firmware write to mode register |
| fw_cnt_wr | input | 1 | Firmware write to counter register |
| fw_wdata | input | 8 | Firmware write data |
| fw_mode_rd | input | 1 | Firmware read of mode register (unlock) |
| fw_cnt_rd | input | 1 | Firmware read of counter register (unlock) |
| mode_reg | output | 8 | SETUP flag, ACK flag, mode field |
| cnt_reg | output | CNT_W+2 | Toggle, valid, byte count |
| hs_valid | output | 1 | Handshake answer present |
| hs_code | output | 2 | Handshake choice |
| ep_irq | output | 1 | Endpoint interrupt pulse |

## Verification
The bench sweeps all sixteen modes against every token kind, both packet-quality values and both host-acknowledge values. For each case it predicts the answer, the interrupt and the register contents from the mode tables. A wrong table entry shows up as a bad handshake code. A design that stalled or refused SETUP would fail the SETUP rows in every mode. A design that moved the mode after any accepted OUT, and not only after a status OUT in mode 1111, would leave a wrong mode field in modes 1001 and 1110. After every case the bench tries a firmware write before reading. A design with missing or leaky locks would take that write. A design that never unlocked would refuse the setup write of the next case. A separate sequence checks that the SETUP flag locks early and that the flag is not touched in the disabled mode.

// File: rtl/ctl_ep_mode.sv
module ctl_ep_mode #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             setup_seen,
  input  logic             tok_valid,
  input  logic [1:0]       tok_kind,
  input  logic             tok_ok,
  input  logic             tok_dtog,
  input  logic [CNT_W-1:0] tok_len,
  input  logic             host_ack,
  input  logic             fw_mode_wr,
  input  logic             fw_cnt_wr,
  input  logic [7:0]       fw_wdata,
  input  logic             fw_mode_rd,
  input  logic             fw_cnt_rd,
  output logic [7:0]       mode_reg,
  output logic [CNT_W+1:0] cnt_reg,
  output logic             hs_valid,
  output logic [1:0]       hs_code,
  output logic             ep_irq
);
  localparam logic [1:0] K_SETUP = 2'd0, K_IN = 2'd1, K_OUT = 2'd2;
  localparam logic [1:0] R_IGN = 2'd0, R_ACK = 2'd1, R_NAK = 2'd2, R_STALL = 2'd3;

  logic [3:0]       mode_q;
  logic             setup_q, ack_q, mode_lk, cnt_lk, dtog_q, dval_q;
  logic [CNT_W-1:0] len_q;
  logic [1:0]       rsp;
  logic             data_acc;

  assign mode_reg = {setup_q, 2'b00, ack_q, mode_q};
  assign cnt_reg  = {dtog_q, dval_q, len_q};
  assign data_acc = (rsp == R_ACK) && (tok_kind != K_IN);

  always_comb begin
    rsp = R_IGN;
    if (tok_valid && mode_q != 4'b0000) begin
      case (tok_kind)
        K_SETUP: if (tok_ok) rsp = R_ACK;
        K_IN: case (mode_q)
          4'b0011:                                  rsp = R_STALL;
          4'b1101, 4'b1111:                         rsp = R_ACK;
          4'b0001, 4'b1000, 4'b1001, 4'b1100, 4'b1110: rsp = R_NAK;
          default:                                  rsp = R_IGN;
        endcase
        K_OUT: if (tok_ok) begin
          case (mode_q)
            4'b0011:                         rsp = R_STALL;
            4'b1001, 4'b1110, 4'b1111:       rsp = R_ACK;
            4'b0001, 4'b1000, 4'b1100, 4'b1101: rsp = R_NAK;
            default:                         rsp = R_IGN;
          endcase
        end
        default: rsp = R_IGN;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q   <= '0;
      setup_q  <= 1'b0;
      ack_q    <= 1'b0;
      mode_lk  <= 1'b0;
      cnt_lk   <= 1'b0;
      dtog_q   <= 1'b0;
      dval_q   <= 1'b0;
      len_q    <= '0;
      hs_valid <= 1'b0;
      hs_code  <= R_IGN;
      ep_irq   <= 1'b0;
    end else begin
      hs_valid <= (rsp != R_IGN);
      hs_code  <= rsp;
      ep_irq   <= (rsp == R_ACK) || (rsp == R_STALL);
      if (fw_mode_rd) mode_lk <= 1'b0;
      if (fw_cnt_rd)  cnt_lk  <= 1'b0;
      if (fw_mode_wr && !mode_lk) begin
        setup_q <= fw_wdata[7];
        ack_q   <= fw_wdata[4];
        mode_q  <= fw_wdata[3:0];
      end
      if (fw_cnt_wr && !cnt_lk) begin
        dtog_q <= fw_wdata[7];
        dval_q <= fw_wdata[6];
        len_q  <= fw_wdata[CNT_W-1:0];
      end
      if (setup_seen && mode_q != 4'b0000) begin
        setup_q <= 1'b1;
        mode_lk <= 1'b1;
      end
      if (rsp != R_IGN) begin
        mode_lk <= 1'b1;
        ack_q   <= (rsp == R_ACK) && ((tok_kind != K_IN) || host_ack);
      end
      if (data_acc) begin
        dtog_q <= tok_dtog;
        dval_q <= 1'b1;
        len_q  <= tok_len;
        cnt_lk <= 1'b1;
        if (tok_kind == K_SETUP) setup_q <= 1'b1;
        if (tok_kind == K_OUT && mode_q == 4'b1111) mode_q <= 4'b1110;
      end
    end
  end
endmodule

// File: rtl/ctl_ep_mode_chk.sv
module ctl_ep_mode_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       setup_seen,
  input logic       tok_valid,
  input logic [1:0] tok_kind,
  input logic       tok_ok,
  input logic       fw_mode_wr,
  input logic       mode_lk,
  input logic [7:0] mode_reg,
  input logic       hs_valid,
  input logic [1:0] hs_code,
  input logic       ep_irq
);
  AST_SETUP_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (tok_valid && tok_kind == 2'd0 && tok_ok && mode_reg[3:0] != 4'd0) |=> (hs_valid && hs_code == 2'd1)); // R3
  AST_STATUS_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (tok_valid && tok_kind == 2'd2 && tok_ok && mode_reg[3:0] == 4'hF) |=> (mode_reg[3:0] == 4'hE)); // R6
  AST_LOCK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_lk && fw_mode_wr && !tok_valid && !setup_seen) |=> $stable(mode_reg)); // R7
  AST_SETUP_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
    (setup_seen && mode_reg[3:0] != 4'd0) |=> mode_reg[7]); // R8
  AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    ep_irq |-> (hs_valid && hs_code != 2'd2)); // R9
  AST_HS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !tok_valid |=> !hs_valid); // R2
endmodule

bind ctl_ep_mode ctl_ep_mode_chk u_chk (
  .clk(clk), .rst_n(rst_n), .setup_seen(setup_seen), .tok_valid(tok_valid),
  .tok_kind(tok_kind), .tok_ok(tok_ok), .fw_mode_wr(fw_mode_wr), .mode_lk(mode_lk),
  .mode_reg(mode_reg), .hs_valid(hs_valid), .hs_code(hs_code), .ep_irq(ep_irq)
);

// File: tb/test_ctl_ep_mode.sv
module test_ctl_ep_mode;
  localparam int CNT_W = 6;
  logic clk = 0, rst_n = 0;
  logic setup_seen = 0, tok_valid = 0, tok_ok = 0, tok_dtog = 0, host_ack = 0;
  logic [1:0] tok_kind = 0;
  logic [CNT_W-1:0] tok_len = 0;
  logic fw_mode_wr = 0, fw_cnt_wr = 0, fw_mode_rd = 0, fw_cnt_rd = 0;
  logic [7:0] fw_wdata = 0;
  logic [7:0] mode_reg;
  logic [CNT_W+1:0] cnt_reg;
  logic hs_valid, ep_irq;
  logic [1:0] hs_code;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  ctl_ep_mode #(.CNT_W(CNT_W)) i_ctl_ep_mode (
    .clk(clk), .rst_n(rst_n), .setup_seen(setup_seen), .tok_valid(tok_valid),
    .tok_kind(tok_kind), .tok_ok(tok_ok), .tok_dtog(tok_dtog), .tok_len(tok_len),
    .host_ack(host_ack), .fw_mode_wr(fw_mode_wr), .fw_cnt_wr(fw_cnt_wr),
    .fw_wdata(fw_wdata), .fw_mode_rd(fw_mode_rd), .fw_cnt_rd(fw_cnt_rd),
    .mode_reg(mode_reg), .cnt_reg(cnt_reg), .hs_valid(hs_valid),
    .hs_code(hs_code), .ep_irq(ep_irq));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int want(int m, int k, bit ok);
    if (m == 0) return 0;
    if (k == 0) return ok ? 1 : 0;
    if (k == 1) begin
      if (m == 3) return 3;
      if (m == 13 || m == 15) return 1;
      if (m == 1 || m == 8 || m == 9 || m == 12 || m == 14) return 2;
      return 0;
    end
    if (!ok) return 0;
    if (m == 3) return 3;
    if (m == 9 || m == 14 || m == 15) return 1;
    if (m == 1 || m == 8 || m == 12 || m == 13) return 2;
    return 0;
  endfunction

  task automatic unlock_and_load(logic [7:0] mv, logic [7:0] cv);
    fw_mode_rd = 1; fw_cnt_rd = 1;
    @(negedge clk);
    fw_mode_rd = 0; fw_cnt_rd = 0;
    fw_mode_wr = 1; fw_cnt_wr = 1; fw_wdata = mv;
    @(negedge clk);
    fw_cnt_wr = 0; fw_mode_wr = 0; fw_cnt_wr = 1; fw_wdata = cv;
    @(negedge clk);
    fw_cnt_wr = 0;
    chk("R7 write after unlock mode", mode_reg, mv);
    chk("R7 write after unlock cnt", cnt_reg, cv);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 mode_reg", mode_reg, 0);
    chk("R1 cnt_reg", cnt_reg, 0);
    chk("R1 hs_valid", hs_valid, 0);
    chk("R1 ep_irq", ep_irq, 0);

    for (int m = 0; m < 16; m++)
      for (int k = 0; k < 3; k++)
        for (int okv = 0; okv < 2; okv++)
          for (int ha = 0; ha < 2; ha++) begin
            int r;
            logic [7:0] em, ec;
            logic [CNT_W-1:0] ln;
            logic dt;
            r  = want(m, k, okv[0]);
            ln = CNT_W'((m * 3 + k * 7 + ha) % 64);
            dt = m[0] ^ ha[0];
            unlock_and_load({4'b0001, m[3:0]}, 8'h15);
            em = {4'b0001, m[3:0]};
            ec = 8'h15;
            if (r == 1) begin
              if (k != 1) begin
                ec = {dt, 1'b1, ln};
                if (k == 0) em[7] = 1'b1;
                if (k == 2 && m == 15) em[3:0] = 4'hE;
              end else em[4] = ha[0];
            end else if (r != 0) em[4] = 1'b0;
            tok_valid = 1; tok_kind = k[1:0]; tok_ok = okv[0];
            tok_dtog = dt; tok_len = ln; host_ack = ha[0];
            @(negedge clk);
            tok_valid = 0;
            chk("R2 hs_valid", hs_valid, (r != 0));
            chk("R2 hs_code", hs_code, r);
            if (k == 0 && m != 0 && okv == 1) chk("R3 setup ack", hs_code, 1);
            chk("R9 ep_irq", ep_irq, (r == 1 || r == 3));
            chk("R5 R6 mode_reg", mode_reg, em);
            chk("R4 cnt_reg", cnt_reg, ec);
            @(negedge clk);
            chk("R9 irq pulse ends", ep_irq, 0);
            fw_mode_wr = 1; fw_cnt_wr = 1; fw_wdata = 8'h17;
            @(negedge clk);
            fw_mode_wr = 0; fw_cnt_wr = 0;
            chk("R7 mode lock", mode_reg, (r != 0) ? em : 8'h17);
            chk("R7 cnt lock", cnt_reg, (r == 1 && k != 1) ? ec : 8'h17);
          end

    unlock_and_load(8'h01, 8'h00);
    setup_seen = 1;
    @(negedge clk);
    setup_seen = 0;
    chk("R8 setup flag early", mode_reg, 8'h81);
    fw_mode_wr = 1; fw_wdata = 8'h01;
    @(negedge clk);
    fw_mode_wr = 0;
    chk("R8 setup lock", mode_reg, 8'h81);
    unlock_and_load(8'h00, 8'h00);
    setup_seen = 1;
    @(negedge clk);
    setup_seen = 0;
    chk("R8 disabled no flag", mode_reg, 8'h00);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule